// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller for an integrating analog-to-digital front end. It drives the front end through one measurement at a time. A start pulse begins the sequence. The integrator is first shorted and held at its zero input for a programmable number of clocks. The unknown signal is then applied for exactly 2^N clocks. After that, a reference of opposite polarity is applied, and the number of clocks the integrator needs to fall back to its starting level is counted. One counter times both the fixed window and the variable window. The ratio of the two windows therefore gives the result, so neither the clock rate nor the integrator time constant affects it.

The comparator output is asynchronous. It passes through a two-flop synchroniser, and the latency that this adds is removed from the count. A sign input from the front end chooses which reference is applied and is reported with the result. If the comparator never trips, a timeout ends the conversion with an overrange flag. The result is a one-cycle `done` pulse with no back-pressure. The result, sign and flag outputs stay steady until the next conversion finishes. There is no valid/ready interface, because the result cannot be held back and every control pin is a plain level.

Top module: `dslope_seq`

## Requirements
- R1: While reset is held and after it is released, all four input selects, the integrator reset, `done_o`, `ovr_o`, `sign_o` and `result_o` are 0.
- R2: A start pulse in idle leads to an autozero phase of exactly AZ_CYCLES clocks. During it, `sel_zero_o` and `int_rst_o` are both 1. Autozero is followed only by run-up, and at most one select is high in any cycle.
- R3: Run-up holds `sel_sig_o` high for exactly 2^N clocks. In the last run-up clock `sign_i` is sampled. Run-down then applies the opposite reference: `sign_i`=0 (positive input) selects `sel_refn_o`, and `sign_i`=1 selects `sel_refp_o`. The sampled sign is reported on `sign_o`.
- R4: `cmp_i` (1 = the integrator is back at or past its autozero level) goes through a two-flop synchroniser. If the synchronised comparator is first seen high in run-down clock k (counting from 0), the result is k−2, floored at 0. With an integrator that trips after m reference clocks, the result is m.
- R5: When the comparator trips at run-down clock k, `done_o` is high in the cycle after the clock edge numbered AZ_CYCLES+2^N+k+2, counting the edge that samples start as 1.
- R6: `done_o` is high for exactly one clock. `result_o`, `sign_o` and `ovr_o` change only together with `done_o`.
- R7: The conversion ends with `ovr_o`=1 and `result_o` all ones if the synchronised comparator is still low in run-down clock 2^N+3, which is 2^N+1 clocks plus the synchroniser latency. Run-down then lasts 2^N+4 clocks.
- R8: If the comparator trips but k−2 ≥ 2^N, then `result_o` saturates to all ones and `ovr_o` is 0.
- R9: A start pulse during a conversion is ignored: the result and timing are unchanged, and no new autozero follows `done_o`.
- R10: If the comparator is already high when run-down begins, the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, acted on only in idle |
| cmp_i | input | 1 | Asynchronous comparator, 1 = integrator back at zero level |
| sign_i | input | 1 | Input polarity from front end, 1 = negative |
| sel_zero_o | output | 1 | Integrator input tied to zero |
| sel_sig_o | output | 1 | Integrator input tied to unknown signal |
| sel_refp_o | output | 1 | Integrator input tied to positive reference |
| sel_refn_o | output | 1 | Integrator input tied to negative reference |
| int_rst_o | output | 1 | Integrator discharge |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | N | Converted magnitude |
| sign_o | output | 1 | Sign reported with the result |
| ovr_o | output | 1 | Overrange (timeout) flag |

## Verification
A behavioural integrator in the bench adds the input value each run-up clock and subtracts the full-scale reference each run-down clock. It uses the reference sign to check that the polarity chosen is the right one: the wrong reference drives the integrator away from zero, so the comparator never trips. Small, middle and near-full-scale inputs separate a correct count from an off-by-one in the synchroniser compensation. The total-latency and per-phase clock counts expose errors in the window lengths. A zero input shows the floor at 0. An exactly full-scale input shows saturation without overrange. A comparator held low shows the timeout path. A mid-run start pulse and a result sampled during the next conversion show that busy starts are ignored and that the result holds.

// File: rtl/dslope_pkg.sv
package dslope_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_AZERO = 2'd1,
    PH_RUNUP = 2'd2,
    PH_RUNDN = 2'd3
  } phase_t;
endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dslope_fsm.sv
module dslope_fsm
  import dslope_pkg::*;
#(
  parameter int N         = 8,
  parameter int AZ_CYCLES = 16,
  parameter int SYNC_LAT  = 2,
  parameter int CW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cmp_s_i,
  input  logic          sign_i,
  output phase_t        phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          end_o,
  output logic          trip_o,
  output logic          sign_q_o
);
  localparam logic [CW-1:0] AZ_LAST = CW'(AZ_CYCLES - 1);
  localparam logic [CW-1:0] RU_LAST = CW'((1 << N) - 1);
  localparam logic [CW-1:0] TMO     = CW'((1 << N) + 1 + SYNC_LAT);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          sign_q;

  assign trip_o   = cmp_s_i;
  assign end_o    = (phase == PH_RUNDN) && (cmp_s_i || (cnt == TMO));
  assign phase_o  = phase;
  assign cnt_o    = cnt;
  assign sign_q_o = sign_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      sign_q <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start_i) begin
            phase <= PH_AZERO;
            cnt   <= '0;
          end
        end
        PH_AZERO: begin
          if (cnt == AZ_LAST) begin
            phase <= PH_RUNUP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RUNUP: begin
          if (cnt == RU_LAST) begin
            phase  <= PH_RUNDN;
            cnt    <= '0;
            sign_q <= sign_i;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RUNDN: begin
          if (end_o) phase <= PH_IDLE;
          else       cnt   <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dslope_result.sv
module dslope_result #(
  parameter int N        = 8,
  parameter int SYNC_LAT = 2,
  parameter int CW       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          end_i,
  input  logic          trip_i,
  input  logic          sign_i,
  input  logic [CW-1:0] cnt_i,
  output logic          done_o,
  output logic [N-1:0]  result_o,
  output logic          sign_o,
  output logic          ovr_o
);
  localparam logic [CW-1:0] LAT  = CW'(SYNC_LAT);
  localparam logic [CW-1:0] MAXV = CW'((1 << N) - 1);

  logic [CW-1:0] net;
  logic [N-1:0]  clipped;

  always_comb begin
    net     = (cnt_i <= LAT) ? '0 : (cnt_i - LAT);
    clipped = (net > MAXV) ? '1 : net[N-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      result_o <= '0;
      sign_o   <= 1'b0;
      ovr_o    <= 1'b0;
    end else begin
      done_o <= end_i;
      if (end_i) begin
        sign_o   <= sign_i;
        ovr_o    <= !trip_i;
        result_o <= trip_i ? clipped : '1;
      end
    end
  end
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int N           = 8,
  parameter int AZ_CYCLES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         cmp_i,
  input  logic         sign_i,
  output logic         sel_zero_o,
  output logic         sel_sig_o,
  output logic         sel_refp_o,
  output logic         sel_refn_o,
  output logic         int_rst_o,
  output logic         done_o,
  output logic [N-1:0] result_o,
  output logic         sign_o,
  output logic         ovr_o
);
  localparam int SYNC_LAT = SYNC_STAGES;
  localparam int AZW      = $clog2(AZ_CYCLES + 1);
  localparam int CW       = (AZW > N + 2) ? AZW : N + 2;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          cmp_s, end_w, trip_w, sign_q;

  dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cmp_i), .q_o(cmp_s)
  );

  dslope_fsm #(.N(N), .AZ_CYCLES(AZ_CYCLES), .SYNC_LAT(SYNC_LAT), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_s_i(cmp_s),
    .sign_i(sign_i), .phase_o(phase), .cnt_o(cnt), .end_o(end_w),
    .trip_o(trip_w), .sign_q_o(sign_q)
  );

  dslope_result #(.N(N), .SYNC_LAT(SYNC_LAT), .CW(CW)) u_res (
    .clk(clk), .rst_n(rst_n), .end_i(end_w), .trip_i(trip_w),
    .sign_i(sign_q), .cnt_i(cnt), .done_o(done_o), .result_o(result_o),
    .sign_o(sign_o), .ovr_o(ovr_o)
  );

  assign sel_zero_o = (phase == PH_AZERO);
  assign int_rst_o  = (phase == PH_AZERO);
  assign sel_sig_o  = (phase == PH_RUNUP);
  assign sel_refp_o = (phase == PH_RUNDN) &&  sign_q;
  assign sel_refn_o = (phase == PH_RUNDN) && !sign_q;
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel_zero_o,
  input logic         sel_sig_o,
  input logic         sel_refp_o,
  input logic         sel_refn_o,
  input logic         done_o,
  input logic [N-1:0] result_o,
  input logic         sign_o,
  input logic         ovr_o
);
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_zero_o, sel_sig_o, sel_refp_o, sel_refn_o}));

  a_r2_az_then_runup: assert property (@(posedge clk) disable iff (!rst_n)
    sel_zero_o |=> (sel_zero_o || sel_sig_o));

  a_r3_ref_after_signal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_refp_o || sel_refn_o) |-> $past(sel_sig_o));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(sign_o) && $stable(ovr_o)));

  a_r7_ovr_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> (result_o == {N{1'b1}}));

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sel_sig_o |=> !sel_zero_o);
endmodule

bind dslope_seq dslope_seq_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_zero_o(sel_zero_o), .sel_sig_o(sel_sig_o),
  .sel_refp_o(sel_refp_o), .sel_refn_o(sel_refn_o), .done_o(done_o),
  .result_o(result_o), .sign_o(sign_o), .ovr_o(ovr_o)
);

// File: tb/dslope_seq_test.sv
module dslope_seq_test;
  localparam int N  = 8;
  localparam int AZ = 16;
  localparam int FS = 1 << N;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sign_drv = 1'b0;
  logic cmp;
  logic sel_zero, sel_sig, sel_refp, sel_refn, int_rst, done, sign_out, ovr;
  logic [N-1:0] result;

  int n_chk = 0, n_fail = 0;
  int vin = 0;
  int acc = 0;
  bit stuck = 1'b0;

  always #10 clk = ~clk;

  dslope_seq #(.N(N), .AZ_CYCLES(AZ), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp), .sign_i(sign_drv),
    .sel_zero_o(sel_zero), .sel_sig_o(sel_sig), .sel_refp_o(sel_refp),
    .sel_refn_o(sel_refn), .int_rst_o(int_rst), .done_o(done),
    .result_o(result), .sign_o(sign_out), .ovr_o(ovr)
  );

  // behavioural integrator: the correct reference pulls it back toward zero
  always @(posedge clk) begin
    if (int_rst) acc <= 0;
    else if (sel_sig) acc <= acc + vin;
    else if (sel_refp || sel_refn) begin
      if (sel_refp == sign_drv) acc <= acc - FS;
      else                      acc <= acc + FS;
    end
  end
  assign cmp = stuck ? 1'b0 : (acc <= 0);

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int lat, az_n, sig_n, rp_n, rn_n, mid_res;

  task automatic run_conv(input int v, input bit s, input bit extra_start);
    vin = v; sign_drv = s;
    lat = 0; az_n = 0; sig_n = 0; rp_n = 0; rn_n = 0; mid_res = -1;
    @(negedge clk); start = 1'b1;
    forever begin
      @(posedge clk); lat++;
      @(negedge clk);
      start = 1'b0;
      if (extra_start && lat == 50) start = 1'b1;
      if (lat == 100) mid_res = int'(result);
      if (sel_zero && int_rst) az_n++;
      if (sel_sig) sig_n++;
      if (sel_refp) rp_n++;
      if (sel_refn) rn_n++;
      if (done) break;
      if (lat > 5000) begin
        chk("watchdog", 1'b0, lat, 0);
        break;
      end
    end
  endtask

  task automatic t_reset;
    chk("R1 selects", {sel_zero, sel_sig, sel_refp, sel_refn, int_rst} == 5'b0,
        int'({sel_zero, sel_sig, sel_refp, sel_refn, int_rst}), 0);
    chk("R1 outputs", {done, ovr, sign_out} == 3'b0 && result == '0,
        int'(result), 0);
  endtask

  task automatic t_value(input int m, input bit s);
    run_conv(m, s, 1'b0);
    chk("R4 result", int'(result) == m, int'(result), m);
    chk("R2 autozero length", az_n == AZ, az_n, AZ);
    chk("R3 run-up length", sig_n == FS, sig_n, FS);
    chk("R3 ref polarity", s ? (rp_n == m + 3 && rn_n == 0) : (rn_n == m + 3 && rp_n == 0),
        s ? rp_n : rn_n, m + 3);
    chk("R3 sign out", sign_out == s, int'(sign_out), int'(s));
    chk("R5 latency", lat == AZ + FS + m + 4, lat, AZ + FS + m + 4);
    chk("R4 no ovr", ovr == 1'b0, int'(ovr), 0);
  endtask

  task automatic t_zero;
    run_conv(0, 1'b0, 1'b0);
    chk("R10 zero input", result == '0 && !ovr, int'(result), 0);
  endtask

  task automatic t_full;
    run_conv(FS, 1'b0, 1'b0);
    chk("R8 saturate", int'(result) == FS - 1, int'(result), FS - 1);
    chk("R8 no ovr", ovr == 1'b0, int'(ovr), 0);
  endtask

  task automatic t_timeout;
    stuck = 1'b1;
    run_conv(30, 1'b1, 1'b0);
    stuck = 1'b0;
    chk("R7 ovr flag", ovr == 1'b1, int'(ovr), 1);
    chk("R7 all ones", int'(result) == FS - 1, int'(result), FS - 1);
    chk("R7 run-down length", rp_n == FS + 4, rp_n, FS + 4);
  endtask

  task automatic t_ignore;
    run_conv(40, 1'b0, 1'b1);
    chk("R9 result", int'(result) == 40, int'(result), 40);
    chk("R9 latency", lat == AZ + FS + 44, lat, AZ + FS + 44);
    @(negedge clk);
    chk("R6 done one clock", done == 1'b0, int'(done), 0);
    repeat (4) @(negedge clk);
    chk("R9 no restart", !sel_zero && !sel_sig, int'(sel_zero), 0);
  endtask

  task automatic t_hold;
    run_conv(100, 1'b1, 1'b0);
    chk("R6 result held mid-run", mid_res == 40, mid_res, 40);
    chk("R6 new result", int'(result) == 100 && sign_out, int'(result), 100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_value(1, 1'b0);
    t_value(40, 1'b0);
    t_value(200, 1'b0);
    t_value(255, 1'b0);
    t_value(77, 1'b1);
    t_zero();
    t_full();
    t_timeout();
    t_ignore();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule